// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus. It serves a small non-volatile byte array, 16 entries of 8 bits by default. It watches the clock and data lines for START and STOP conditions. It shifts in control, address and data bytes and shifts out read data. It acknowledges by pulling the data line low. The data line is open-drain: the block only ever pulls it low, and a pull-up outside the block returns it high.

Three operations are supported:
- **Byte write:** a write control byte, a word address, one data byte, then STOP.
- **Current-address read:** a read control byte straight after START. Data comes from an internal pointer.
- **Random read:** a write control byte and a word address, then a repeated START and a read control byte.

The pointer advances after every byte written or read, and it wraps at the top of the array. A STOP that closes a byte write starts a programming interval. Its length is counted in system clocks. The array is updated when the interval ends. Until then the slave acknowledges nothing, so a master can poll it to learn when it is free.

Top module: `nvm2w_slave`

## Requirements
- R1: After reset, and with no bus activity, the slave does not pull the data line low.
- R2: The control byte carries the device code in bits 7:1 and a direction flag in bit 0, where 1 means read. With a matching code, the slave holds the data line low for the whole high phase of the ninth clock. With any other code it does not acknowledge.
- R3: In a byte write, the control byte, the word address and the data byte are each acknowledged. After the STOP and the programming interval, the data byte is held at the entry selected by the low 4 address bits. The upper address bits are ignored.
- R4: After the STOP of a byte write, for BUSY_CYCLES system clocks, the slave acknowledges no control byte. Once the interval has ended, a matching control byte is acknowledged again.
- R5: A random read returns the byte held at the low 4 bits of the supplied address.
- R6: A current-address read returns the byte at the internal pointer. After a byte write to address A, the pointer holds A+1.
- R7: In a read, when the master acknowledges a byte, the slave sends the next entry. The pointer wraps from entry 15 to entry 0.
- R8: When the master does not acknowledge a read byte, the transfer ends and the slave releases the data line, so the master can issue STOP.
- R9: A second data byte inside one write transfer is not acknowledged and is not stored.
- R10: If a repeated START replaces the STOP after a data byte, the write is dropped. No programming interval starts and the array is unchanged.
- R11: Apart from START and STOP, the slave changes its data-line drive only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both bus lines are sampled on it |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen on the wire |
| sdaIn | input | 1 | Bus data line as seen on the wire (wired-AND of all drivers) |
| sdaPullLow | output | 1 | 1 pulls the data line low; 0 releases it to the pull-up |

## Verification
A table of writes is run first. Each entry is written and then read back at random. The addresses include one with upper bits set, which tells apart a decoder that uses only the low nibble from one that uses the full byte.

Directed transfers then cover the other cases:
- A wrong device code, which separates an address match from plain byte counting.
- A control byte sent straight after a STOP, which shows the busy refusal.
- A current-address read, which shows that the pointer is left at address+1.
- A two-byte read that starts at entry 15, which shows the wrap.
- An extra data byte, and a write aborted by a repeated START, which show that only a clean STOP commits one byte.

// File: rtl/nvm2w_pkg.sv
package nvm2w_pkg;

  // Strobes from the bus controller to the storage datapath.
  typedef struct packed {
    logic       busStart;  // START or repeated START seen
    logic       busStop;   // STOP seen
    logic       setPtr;    // load pointer from byteVal
    logic       bumpPtr;   // advance pointer (read byte issued)
    logic       holdWr;    // capture byteVal for programming at pointer
    logic [7:0] byteVal;   // last received byte
  } memCmd_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_ADDR,
    S_WDATA,
    S_RDATA,
    S_WAIT
  } busPhase_t;

endpackage

// File: rtl/nvm2w_store.sv
module nvm2w_store
  import nvm2w_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int BUSY_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  memCmd_t    cmd,
  output logic [7:0] rdByte,
  output logic       busy
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [AW-1:0] holdAddr;
  logic [7:0]    holdData;
  logic          pending;
  logic [CW-1:0] busyCnt;
  logic          commitNow;
  logic          unusedAddrHi;

  assign unusedAddrHi = ^cmd.byteVal[7:AW];
  assign rdByte       = mem[ptr];
  assign commitNow    = busy && (busyCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      holdAddr <= '0;
      holdData <= '0;
    end else if (cmd.setPtr) begin
      ptr <= cmd.byteVal[AW-1:0];
    end else if (cmd.holdWr) begin
      holdAddr <= ptr;
      holdData <= cmd.byteVal;
      ptr      <= ptr + AW'(1);
    end else if (cmd.bumpPtr) begin
      ptr <= ptr + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      busy    <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (cmd.holdWr) begin
        pending <= 1'b1;
      end else if (cmd.busStop && pending && !busy) begin
        pending <= 1'b0;
        busy    <= 1'b1;
        busyCnt <= CW'(BUSY_CYCLES - 1);
      end else if (cmd.busStart) begin
        pending <= 1'b0;
      end
      if (busy) begin
        if (busyCnt == '0) busy <= 1'b0;
        else               busyCnt <= busyCnt - CW'(1);
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   mem[i] <= '0;
      else if (commitNow && holdAddr == AW'(i))    mem[i] <= holdData;
    end
  end

  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.bumpPtr && !cmd.setPtr && !cmd.holdWr && ptr == AW'(DEPTH - 1)) |=> (ptr == '0));

  // R4
  prog_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.busStop && pending && !busy) |=> busy);

  // R4
  prog_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitNow |=> !busy);

endmodule

// File: rtl/nvm2w_ctrl.sv
module nvm2w_ctrl
  import nvm2w_pkg::*;
#(
  parameter logic [6:0] DEV_CODE = 7'h50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  input  logic       busy,
  output memCmd_t    cmd,
  output logic       sdaDrive
);

  busPhase_t  state, nextSt;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic       sclPrev, sdaPrev;
  logic       startDet, stopDet, sclRise, sclFall;
  logic       ctrlMatch, inXfer, ackSlotFall, endSlotFall;

  assign startDet    = sclIn && sclPrev && sdaPrev && !sdaIn;
  assign stopDet     = sclIn && sclPrev && !sdaPrev && sdaIn;
  assign sclRise     = sclIn && !sclPrev;
  assign sclFall     = !sclIn && sclPrev;
  assign ctrlMatch   = (shiftReg[7:1] == DEV_CODE) && !busy;
  assign inXfer      = (state != S_IDLE) && (state != S_WAIT) && !startDet && !stopDet;
  assign ackSlotFall = inXfer && sclFall && (bitCnt == 4'd8);
  assign endSlotFall = inXfer && sclFall && (bitCnt == 4'd9);

  always_comb begin
    cmd          = '0;
    cmd.busStart = startDet;
    cmd.busStop  = stopDet;
    cmd.byteVal  = shiftReg;
    cmd.setPtr   = ackSlotFall && (state == S_ADDR);
    cmd.holdWr   = ackSlotFall && (state == S_WDATA);
    cmd.bumpPtr  = endSlotFall && (nextSt == S_RDATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      nextSt   <= S_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      sdaDrive <= 1'b0;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;
      if (stopDet) begin
        state    <= S_IDLE;
        sdaDrive <= 1'b0;
      end else if (startDet) begin
        state    <= S_CTRL;
        bitCnt   <= '0;
        sdaDrive <= 1'b0;
      end else if (inXfer) begin
        if (sclRise) begin
          if (bitCnt < 4'd8) begin
            bitCnt <= bitCnt + 4'd1;
            if (state != S_RDATA) shiftReg <= {shiftReg[6:0], sdaIn};
          end else if (bitCnt == 4'd8) begin
            bitCnt <= 4'd9;
            if (state == S_RDATA && sdaIn) state <= S_WAIT;  // master NACK
          end
        end else if (sclFall) begin
          if (bitCnt == 4'd8) begin
            case (state)
              S_CTRL: begin
                if (ctrlMatch) begin
                  sdaDrive <= 1'b1;
                  nextSt   <= shiftReg[0] ? S_RDATA : S_ADDR;
                end else begin
                  state <= S_WAIT;
                end
              end
              S_ADDR:  begin sdaDrive <= 1'b1; nextSt <= S_WDATA; end
              S_WDATA: begin sdaDrive <= 1'b1; nextSt <= S_WAIT;  end
              default: sdaDrive <= 1'b0;  // read: hand the ack slot to the master
            endcase
          end else if (bitCnt == 4'd9) begin
            bitCnt <= '0;
            state  <= nextSt;
            if (nextSt == S_RDATA) begin
              sdaDrive <= ~rdByte[7];
              shiftReg <= {rdByte[6:0], 1'b0};
            end else begin
              sdaDrive <= 1'b0;
            end
          end else if (state == S_RDATA && bitCnt != 4'd0) begin
            sdaDrive <= ~shiftReg[7];
            shiftReg <= {shiftReg[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R4
  no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaDrive);

  // R11
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && sclPrev && !startDet && !stopDet) |=> $stable(sdaDrive));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.setPtr, cmd.holdWr, cmd.bumpPtr}));

  // R8
  nack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |-> !sdaDrive);

endmodule

// File: rtl/nvm2w_slave.sv
module nvm2w_slave
  import nvm2w_pkg::*;
#(
  parameter logic [6:0] DEV_CODE    = 7'h50,
  parameter int         DEPTH       = 16,
  parameter int         BUSY_CYCLES = 500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullLow
);

  memCmd_t    cmd;
  logic [7:0] rdByte;
  logic       busy;

  nvm2w_ctrl #(.DEV_CODE(DEV_CODE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .rdByte   (rdByte),
    .busy     (busy),
    .cmd      (cmd),
    .sdaDrive (sdaPullLow)
  );

  nvm2w_store #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .rdByte (rdByte),
    .busy   (busy)
  );

endmodule

// File: tb/test_nvm2w_slave.sv
`timescale 1ns/1ps
module test_nvm2w_slave;

  localparam int BUSY = 300;
  localparam logic [7:0] CW_WR = 8'hA0;
  localparam logic [7:0] CW_RD = 8'hA1;
  // {address, data}
  localparam logic [15:0] VECS [4] = '{16'h05A5, 16'h3F3C, 16'h0081, 16'h1A5E};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaPullLow;
  logic sdaBus;
  int   nChk = 0;
  int   nFail = 0;
  int   cyc = 0;
  logic done = 1'b0;

  logic a1, a2, a3, a4;
  logic [7:0] d, d2;

  assign sdaBus = sdaM & ~sdaPullLow;

  always #4 clk = ~clk;

  nvm2w_slave #(.DEV_CODE(7'h50), .DEPTH(16), .BUSY_CYCLES(BUSY)) i_nvm2w_slave (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .sdaPullLow(sdaPullLow)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      nChk  = nChk + 1;
      nFail = nFail + 1;
      $display("FAIL watchdog: cycles actual=%0d expected<%0d", cyc, 150000);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; wt(5); scl = 1'b1; wt(10);
    sdaM = 1'b0; wt(10); scl = 1'b0; wt(5);
  endtask

  task automatic busStop();
    sdaM = 1'b0; wt(5); scl = 1'b1; wt(10);
    sdaM = 1'b1; wt(10);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s0, s1;
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; wt(5); scl = 1'b1; wt(10); scl = 1'b0; wt(5);
    end
    sdaM = 1'b1; wt(5); scl = 1'b1; wt(1);
    s0 = sdaBus; wt(8); s1 = sdaBus; wt(1);
    scl = 1'b0; wt(5);
    ack = !s0 && !s1;
  endtask

  task automatic recvByte(output logic [7:0] b, input logic masterAck);
    sdaM = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(5); scl = 1'b1; wt(5); b = {b[6:0], sdaBus}; wt(5); scl = 1'b0;
    end
    wt(2); sdaM = ~masterAck; wt(3); scl = 1'b1; wt(10); scl = 1'b0; wt(2);
    sdaM = 1'b1; wt(3);
  endtask

  task automatic writeByte(input logic [7:0] addr, input logic [7:0] data,
                           output logic k1, output logic k2, output logic k3);
    busStart(); sendByte(CW_WR, k1); sendByte(addr, k2); sendByte(data, k3); busStop();
  endtask

  task automatic randRead(input logic [7:0] addr, output logic [7:0] data);
    logic k1, k2, k3;
    busStart(); sendByte(CW_WR, k1); sendByte(addr, k2);
    busStart(); sendByte(CW_RD, k3); recvByte(data, 1'b0); busStop();
    check("R5 random read acks", {29'd0, k1, k2, k3}, 7);
  endtask

  initial begin
    wt(3);
    check("R1 reset drive", sdaPullLow, 0);
    rstN = 1'b1;
    wt(20);
    check("R1 idle drive", sdaPullLow, 0);

    // Vector table: write each entry, wait out programming, read back at random
    for (int k = 0; k < 4; k++) begin
      writeByte(VECS[k][15:8], VECS[k][7:0], a1, a2, a3);
      check("R3 write acks", {29'd0, a1, a2, a3}, 7);
      wt(BUSY + 40);
      randRead(VECS[k][15:8], d);
      check("R3 R5 stored byte", d, VECS[k][7:0]);
    end
    // Upper address bits ignored: 0x0F reaches the byte written through 0x3F
    randRead(8'h0F, d);
    check("R3 low-nibble address", d, 8'h3C);

    // R2: wrong device code
    busStart(); sendByte(8'h90, a1); busStop();
    check("R2 foreign code not acked", a1, 0);
    busStart(); sendByte(CW_WR, a1); busStop();
    check("R2 own code acked", a1, 1);

    // R4: busy refusal
    writeByte(8'h08, 8'h88, a1, a2, a3);
    wt(BUSY + 40);
    writeByte(8'h07, 8'h77, a1, a2, a3);
    busStart(); sendByte(CW_WR, a1); busStop();
    check("R4 no ack while programming", a1, 0);
    wt(BUSY + 40);
    busStart(); sendByte(CW_WR, a1); busStop();
    check("R4 ack after interval", a1, 1);

    // R6: current-address read after write to 0x07 gives entry 0x08
    busStart(); sendByte(CW_RD, a1); recvByte(d, 1'b0);
    check("R8 release after master nack", sdaBus, 1);
    busStop();
    check("R6 current read", d, 8'h88);

    // R7: sequential read wrapping 15 -> 0
    busStart(); sendByte(CW_WR, a1); sendByte(8'h0F, a2);
    busStart(); sendByte(CW_RD, a3); recvByte(d, 1'b1); recvByte(d2, 1'b0);
    check("R8 release after nack", sdaBus, 1);
    busStop();
    check("R7 first byte", d, 8'h3C);
    check("R7 wrapped byte", d2, 8'h81);

    // R9: extra data byte refused and not stored
    busStart(); sendByte(CW_WR, a1); sendByte(8'h02, a2); sendByte(8'h22, a3);
    sendByte(8'h33, a4); busStop();
    check("R9 first data acked", a3, 1);
    check("R9 second data not acked", a4, 0);
    wt(BUSY + 40);
    randRead(8'h02, d);
    check("R9 entry 2", d, 8'h22);
    randRead(8'h03, d);
    check("R9 entry 3 untouched", d, 8'h00);

    // R10: repeated START drops the write
    busStart(); sendByte(CW_WR, a1); sendByte(8'h04, a2); sendByte(8'h44, a3);
    busStart(); sendByte(CW_WR, a4); busStop();
    check("R10 no programming interval", a4, 1);
    wt(BUSY + 40);
    randRead(8'h04, d);
    check("R10 entry 4 unchanged", d, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule